// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet frames from a 64-bit beat stream into host memory. The host supplies a list of receive descriptors. The engine reads each descriptor and checks that it owns it. It then writes frame beats into one or two data buffers named by the descriptor. When the descriptor is done, the engine writes its first word back with ownership returned to the host. A long frame spreads over several descriptors. Start and end markers in the written-back word show where the frame begins and ends, and the frame length appears only in the final descriptor.

The next descriptor is found in one of three ways. An end-of-ring flag sends the engine back to the base address. A chain flag turns the second address into a pointer to the next descriptor. Without either flag, the engine steps 16 bytes forward. If the host has not handed over a descriptor, the engine parks and raises a flag. While parked it throws incoming beats away and counts them. It retries the same descriptor when the host pulses the poll input.

Top module: `rx_desc_dma`

## Requirements
- R1: While the synchronous active-high reset is held, the descriptor pointer is loaded from `base_addr`. After release, `no_desc`, `drop_count` and `rx_ready` read 0, and the first memory access is a read of the descriptor at `base_addr`.
- R2: A descriptor at address P is fetched as two reads: control word at P, then address word at P+8. Descriptor addresses have their low 4 bits forced to zero. Address word bits 31:0 are buffer address A and bits 63:32 are address B.
- R3: A control word with bit 63 (ownership) at 0 is not used. The engine raises `no_desc`, issues no further memory access, and on a `poll` pulse re-reads the same descriptor.
- R4: Every beat offered while `no_desc` is high is accepted and discarded, and `drop_count` rises by one. A beat offered without `rx_sof` while no frame is open is also accepted, discarded and counted.
- R5: Each kept beat is written as one 64-bit word with `mem_wdata` equal to `rx_data`. Successive beats go to successive 8-byte words from the buffer start, and buffer addresses have their low 3 bits forced to zero.
- R6: A buffer's capacity in words is its size field with the low 3 bits ignored, divided by 8. Buffer 1's size is in control bits 58:48 and buffer 2's in bits 47:37. Buffer 1 is filled first, then buffer 2. A buffer-1 size below 8 skips buffer 1 entirely.
- R7: With control bit 35 (chain) set and bit 36 clear, buffer 2 is not used. The next descriptor is read at address B with its low 4 bits cleared.
- R8: With control bit 36 (end of ring) set, buffer 2 is a data buffer even if bit 35 is set, and the next descriptor is read at `base_addr`.
- R9: With neither bit 35 nor bit 36 set, the next descriptor is read at P+16.
- R10: The written-back control word has bit 63 = 0 and bits 62:59 = 0, with bits 58:35 copied from the fetched word. Bit 34 is set if the descriptor received a frame's first beat, and bit 33 if it received the last. Bits 30:20 hold the total frame byte count when bit 33 is set and 0 otherwise. Bits 32:31 and 19:0 are 0. Each beat counts 8 bytes, except the last, which counts `rx_bytes` with 0 meaning 8.
- R11: The write-back goes to address P and is the last access for that descriptor. It comes after every data write to its buffers has been granted, and no beat is accepted while a memory write is pending.
- R12: When a descriptor's buffers fill before the frame ends, it is written back without the end flag and with a zero length field. The frame continues in the next descriptor, and the length written at the end covers every byte of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_addr | input | 32 | Start address of the descriptor list |
| poll | input | 1 | Pulse asking the engine to retry an unowned descriptor |
| rx_valid | input | 1 | Beat offered |
| rx_ready | output | 1 | Engine takes the offered beat this cycle |
| rx_data | input | 64 | Beat data |
| rx_sof | input | 1 | Beat is the first of a frame |
| rx_eof | input | 1 | Beat is the last of a frame |
| rx_bytes | input | 3 | Valid bytes in the last beat, 0 meaning 8 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Read data |
| no_desc | output | 1 | Parked on a descriptor the host still owns |
| drop_count | output | 16 | Number of discarded beats |

## Verification
The hardest case to reach is a frame that spans three descriptors. The first has a zero-size buffer 1, the second is chained through a misaligned pointer, and the third holds the tail. On top of that, the memory grant comes and goes from cycle to cycle. The stimulus builds this chain in the memory model and releases the stalled engine with a poll. It then sends one frame while a shift-register pattern withholds the grant, and compares each write-back and the exact order of the memory writes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 64;
  localparam int SIZE_W   = 11;
  localparam int WCNT_W   = SIZE_W - 3;
  localparam int LEN_W    = 11;
  localparam int BEAT_B   = DATA_W / 8;
  localparam int STAT_LO  = 20;
  localparam int DESC_STEP = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_WT0, ST_RD1, ST_WT1,
    ST_PICK, ST_NODESC, ST_RECV, ST_WR, ST_WB
  } st_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size1;
    logic [SIZE_W-1:0] size2;
    logic              end_ring;
    logic              chained;
  } ctl_t;

  function automatic logic [WCNT_W-1:0] size_words(input logic [SIZE_W-1:0] sz);
    return sz[SIZE_W-1:3];
  endfunction

  function automatic logic [LEN_W-1:0] beat_len(input logic [2:0] b);
    return (b == 3'd0) ? LEN_W'(BEAT_B) : LEN_W'(b);
  endfunction

  function automatic logic [ADDR_W-1:0] align8(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:3], 3'b000};
  endfunction

  function automatic logic [ADDR_W-1:0] align16(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:4], 4'b0000};
  endfunction

  function automatic logic [ADDR_W-1:0] next_desc(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] base,
                                                  input ctl_t c,
                                                  input logic [ADDR_W-1:0] ptr_b);
    if (c.end_ring)     return align16(base);
    else if (c.chained) return align16(ptr_b);
    else                return align16(cur) + ADDR_W'(DESC_STEP);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input ctl_t c, input logic sof,
                                                    input logic eof,
                                                    input logic [LEN_W-1:0] len);
    return {1'b0, 4'b0000, c.size1, c.size2, c.end_ring, c.chained, sof, eof,
            2'b00, (eof ? len : {LEN_W{1'b0}}), {STAT_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/rxd_desc_view.sv
module rxd_desc_view
  import rxd_pkg::*;
(
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] ptrs,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic              sof,
  input  logic              eof,
  input  logic [LEN_W-1:0]  len,
  output logic [WCNT_W-1:0] n1,
  output logic [WCNT_W-1:0] n2,
  output logic [ADDR_W-1:0] a1,
  output logic [ADDR_W-1:0] a2,
  output logic              buf2_ok,
  output logic [ADDR_W-1:0] nxt,
  output logic [DATA_W-1:0] wb_word
);
  logic [ADDR_W-1:0] raw_a, raw_b;

  always_comb begin
    raw_a   = ptrs[ADDR_W-1:0];
    raw_b   = ptrs[DATA_W-1:ADDR_W];
    n1      = size_words(ctl.size1);
    n2      = size_words(ctl.size2);
    a1      = align8(raw_a);
    a2      = align8(raw_b);
    buf2_ok = ctl.end_ring || !ctl.chained;
    nxt     = next_desc(cur, base, ctl, raw_b);
    wb_word = status_word(ctl, sof, eof, len);
  end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  input  logic              chained,
  input  logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)          cur <= align16(base);
    else if (advance) cur <= align16(nxt);
  end

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap) |=> (cur == align16(base))); // R8
  AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance && !wrap && !chained) |=> (cur == $past(cur) + ADDR_W'(DESC_STEP))); // R9
endmodule

// File: rtl/rxd_drop_ctr.sv
module rxd_drop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (hit) count <= count + CNT_W'(1);
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    hit |=> (count == $past(count) + CNT_W'(1))); // R4
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              poll,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [2:0]        rx_bytes,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              no_desc,
  output logic [DROP_W-1:0] drop_count
);
  st_e               st;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] ptr_q;
  logic [ADDR_W-1:0] cur, buf_ptr, nxt, a1, a2;
  logic [WCNT_W-1:0] left, n1, n2;
  logic              sel2, d_sof, d_eof, in_frame, beat_last, buf2_ok;
  logic [LEN_W-1:0]  flen;
  logic [DATA_W-1:0] beat_q, wb_word;

  // named events
  logic ev_accept, ev_drop, ev_take, ev_wr_done, ev_wb_done, ev_own_ok;
  logic unused_rd_bits;

  assign unused_rd_bits = ^{mem_rdata[62:59], mem_rdata[32:0]};

  assign rx_ready   = (st == ST_RECV) || (st == ST_NODESC);
  assign no_desc    = (st == ST_NODESC);
  assign ev_accept  = rx_valid && rx_ready;
  assign ev_drop    = ev_accept && ((st == ST_NODESC) || (!rx_sof && !in_frame));
  assign ev_take    = ev_accept && !ev_drop;
  assign ev_wr_done = (st == ST_WR) && mem_gnt;
  assign ev_wb_done = (st == ST_WB) && mem_gnt;
  assign ev_own_ok  = (st == ST_WT0) && mem_rvalid && mem_rdata[DATA_W-1];

  rxd_desc_view u_view (
    .ctl(ctl_q), .ptrs(ptr_q), .cur(cur), .base(base_addr),
    .sof(d_sof), .eof(d_eof), .len(flen),
    .n1(n1), .n2(n2), .a1(a1), .a2(a2), .buf2_ok(buf2_ok),
    .nxt(nxt), .wb_word(wb_word)
  );

  rxd_ring_ptr u_ring (
    .clk(clk), .rst(rst), .base(base_addr), .advance(ev_wb_done),
    .wrap(ctl_q.end_ring), .chained(ctl_q.chained), .nxt(nxt), .cur(cur)
  );

  rxd_drop_ctr #(.CNT_W(DROP_W)) u_drop (
    .clk(clk), .rst(rst), .hit(ev_drop), .count(drop_count)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (st)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(BEAT_B); end
      ST_WR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = buf_ptr; mem_wdata = beat_q; end
      ST_WB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ctl_q     <= '0;
      ptr_q     <= '0;
      buf_ptr   <= '0;
      left      <= '0;
      sel2      <= 1'b0;
      d_sof     <= 1'b0;
      d_eof     <= 1'b0;
      in_frame  <= 1'b0;
      flen      <= '0;
      beat_q    <= '0;
      beat_last <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: st <= ST_RD0;
        ST_RD0:  if (mem_gnt) st <= ST_WT0;
        ST_WT0: if (mem_rvalid) begin
          ctl_q <= mem_rdata[58:35];
          st    <= ev_own_ok ? ST_RD1 : ST_NODESC;
        end
        ST_RD1:  if (mem_gnt) st <= ST_WT1;
        ST_WT1: if (mem_rvalid) begin
          ptr_q <= mem_rdata;
          st    <= ST_PICK;
        end
        ST_PICK: begin
          if (n1 != '0) begin
            buf_ptr <= a1; left <= n1; sel2 <= 1'b0; st <= ST_RECV;
          end else if (buf2_ok && n2 != '0) begin
            buf_ptr <= a2; left <= n2; sel2 <= 1'b1; st <= ST_RECV;
          end else begin
            st <= ST_WB;
          end
        end
        ST_NODESC: begin
          if (ev_drop) in_frame <= 1'b0;
          if (poll) st <= ST_RD0;
        end
        ST_RECV: if (ev_take) begin
          beat_q    <= rx_data;
          beat_last <= rx_eof;
          if (rx_sof) d_sof <= 1'b1;
          flen      <= (rx_sof ? '0 : flen) + (rx_eof ? beat_len(rx_bytes) : LEN_W'(BEAT_B));
          in_frame  <= !rx_eof;
          st        <= ST_WR;
        end
        ST_WR: if (ev_wr_done) begin
          buf_ptr <= buf_ptr + ADDR_W'(BEAT_B);
          left    <= left - WCNT_W'(1);
          if (beat_last) begin
            d_eof <= 1'b1;
            st    <= ST_WB;
          end else if (left == WCNT_W'(1)) begin
            if (!sel2 && buf2_ok && n2 != '0) begin
              buf_ptr <= a2; left <= n2; sel2 <= 1'b1; st <= ST_RECV;
            end else begin
              st <= ST_WB;
            end
          end else begin
            st <= ST_RECV;
          end
        end
        ST_WB: if (ev_wb_done) begin
          d_sof <= 1'b0;
          d_eof <= 1'b0;
          st    <= ST_RD0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_NODESC_QUIET: assert property (@(posedge clk) disable iff (rst)
    no_desc |-> !mem_req); // R3
  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000)); // R5
  AST_WR_ROOM: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR) |-> (left != '0)); // R6
  AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (ev_wb_done && d_eof) |-> !in_frame); // R10
  AST_NO_TAKE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !rx_ready); // R11
  AST_DESC_FOLLOWS_WB: assert property (@(posedge clk) disable iff (rst)
    ev_wb_done |=> (mem_req && !mem_we && mem_addr == cur)); // R11
endmodule

// File: tb/sim_rx_desc_dma.sv
module sim_rx_desc_dma;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, poll = 1'b0;
  logic [31:0] base_addr = 32'h100;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [63:0] rx_data = '0;
  logic [2:0]  rx_bytes = '0;
  logic        rx_ready, mem_req, mem_we, mem_gnt, no_desc;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0, mem_wdata;
  logic [31:0] mem_addr;
  logic [15:0] drop_count;

  rx_desc_dma #(.DROP_W(16)) u0 (
    .clk(clk), .rst(rst), .base_addr(base_addr), .poll(poll),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_bytes(rx_bytes),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .no_desc(no_desc), .drop_count(drop_count)
  );

  logic [63:0] mem [0:511];
  logic [31:0] wlog [0:63];
  logic [31:0] rlog [0:63];
  int wcnt = 0, rcnt = 0, nchk = 0, nbad = 0;
  logic stall_mode = 1'b0, gnt_en = 1'b1;
  logic [7:0] lfsr = 8'hA5;

  assign mem_gnt = mem_req && gnt_en;

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    gnt_en <= stall_mode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:3]] <= mem_wdata;
        if (wcnt < 64) wlog[wcnt] <= mem_addr;
        wcnt <= wcnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:3]];
        if (rcnt < 64) rlog[rcnt] <= mem_addr;
        rcnt <= rcnt + 1;
      end
    end
  end

  function automatic logic [63:0] mk_w0(bit own, int s1, int s2, bit er, bit ch,
                                        bit sof, bit eof, int len);
    logic [63:0] w = '0;
    w = w | (64'(own) << 63) | (64'(s1 & 'h7FF) << 48) | (64'(s2 & 'h7FF) << 37);
    w = w | (64'(er) << 36) | (64'(ch) << 35) | (64'(sof) << 34) | (64'(eof) << 33);
    w = w | (64'(len & 'h7FF) << 20);
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [63:0] d);
    mem[a[11:3]] = d;
  endtask

  task automatic send_beat(input logic [63:0] d, input bit sof, input bit eof,
                           input logic [2:0] nb);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_sof = sof; rx_eof = eof; rx_bytes = nb;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    #2 rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_nodesc(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (no_desc) break;
    end
    chk(req, 64'(no_desc), 64'd1);
  endtask

  // R1 R2 R3 R4: reset, unowned descriptor, drops, poll retry
  task automatic t_reset_stall();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1 no_desc after reset", 64'(no_desc), 64'd0);
    chk("R1 drop_count after reset", 64'(drop_count), 64'd0);
    chk("R1 rx_ready after reset", 64'(rx_ready), 64'd0);
    wait_nodesc("R3 stall on unowned");
    chk("R1 first read at base", 64'(rlog[0]), 64'h100);
    repeat (5) @(negedge clk);
    chk("R3 single read while stalled", 64'(rcnt), 64'd1);
    chk("R3 no writes while stalled", 64'(wcnt), 64'd0);
    send_beat(64'h1111, 1, 0, 0);
    send_beat(64'h2222, 0, 1, 0);
    @(negedge clk);
    chk("R4 drops counted while stalled", 64'(drop_count), 64'd2);
    chk("R4 dropped beats not written", 64'(wcnt), 64'd0);
    put(32'h100, mk_w0(1, 16, 21, 0, 0, 0, 0, 0));
    put(32'h108, {32'h500, 32'h400});
    pulse_poll();
    repeat (10) @(negedge clk);
    chk("R3 no_desc clears after poll", 64'(no_desc), 64'd0);
    chk("R3 read count after poll", 64'(rcnt), 64'd3);
    chk("R3 refetch same descriptor", 64'(rlog[1]), 64'h100);
    chk("R2 address word at P+8", 64'(rlog[2]), 64'h108);
  endtask

  // R4 R5 R6 R9 R10 R11: one frame over buffer 1 and buffer 2
  task automatic t_single_frame();
    int ws;
    ws = wcnt;
    send_beat(64'hBAD0, 0, 0, 0);
    @(negedge clk);
    chk("R4 beat outside frame dropped", 64'(drop_count), 64'd3);
    chk("R4 beat outside frame not written", 64'(wcnt - ws), 64'd0);
    send_beat(64'hA0A0_0000_0000_0001, 1, 0, 0);
    send_beat(64'hA0A0_0000_0000_0002, 0, 0, 0);
    send_beat(64'hA0A0_0000_0000_0003, 0, 1, 5);
    wait_nodesc("R9 stall at next descriptor");
    chk("R11 four writes", 64'(wcnt - ws), 64'd4);
    chk("R5 beat0 address", 64'(wlog[ws]), 64'h400);
    chk("R5 beat1 address", 64'(wlog[ws+1]), 64'h408);
    chk("R6 beat2 in buffer 2", 64'(wlog[ws+2]), 64'h500);
    chk("R11 write-back last", 64'(wlog[ws+3]), 64'h100);
    chk("R5 beat0 data", mem[32'h400 >> 3], 64'hA0A0_0000_0000_0001);
    chk("R5 beat2 data", mem[32'h500 >> 3], 64'hA0A0_0000_0000_0003);
    chk("R10 write-back word", mem[32'h100 >> 3], mk_w0(0, 16, 21, 0, 0, 1, 1, 21));
    chk("R9 next at P+16", 64'(rlog[rcnt-1]), 64'h110);
  endtask

  // R6 R7 R12: zero buffer 1, chained pointer, frame split over three descriptors
  task automatic t_chain_split();
    int ws;
    put(32'h110, mk_w0(1, 0, 8, 0, 0, 0, 0, 0));
    put(32'h118, {32'h600, 32'h123});
    put(32'h120, mk_w0(1, 8, 64, 0, 1, 0, 0, 0));
    put(32'h128, {32'h208, 32'h700});
    put(32'h200, mk_w0(1, 24, 0, 0, 0, 0, 0, 0));
    put(32'h208, {32'h0, 32'h803});
    stall_mode = 1'b1;
    ws = wcnt;
    pulse_poll();
    send_beat(64'hC1, 1, 0, 0);
    send_beat(64'hC2, 0, 0, 0);
    send_beat(64'hC3, 0, 0, 0);
    send_beat(64'hC4, 0, 1, 0);
    wait_nodesc("R12 stall after split frame");
    chk("R12 seven writes", 64'(wcnt - ws), 64'd7);
    chk("R6 zero buffer 1 skipped", 64'(wlog[ws]), 64'h600);
    chk("R12 first descriptor closed", 64'(wlog[ws+1]), 64'h110);
    chk("R7 chained buffer 1", 64'(wlog[ws+2]), 64'h700);
    chk("R7 buffer 2 unused when chained", 64'(wlog[ws+3]), 64'h120);
    chk("R5 misaligned buffer forced", 64'(wlog[ws+4]), 64'h800);
    chk("R11 tail write-back order", 64'(wlog[ws+6]), 64'h200);
    chk("R12 first status", mem[32'h110 >> 3], mk_w0(0, 0, 8, 0, 0, 1, 0, 0));
    chk("R12 middle status", mem[32'h120 >> 3], mk_w0(0, 8, 64, 0, 1, 0, 0, 0));
    chk("R12 final status length", mem[32'h200 >> 3], mk_w0(0, 24, 0, 0, 0, 0, 1, 32));
    chk("R7 chained fetch address", 64'(rlog[rcnt-3]), 64'h200);
    chk("R9 next after chain target", 64'(rlog[rcnt-1]), 64'h210);
  endtask

  // R8: end of ring overrides chaining, returns to base
  task automatic t_end_ring();
    int ws;
    put(32'h210, mk_w0(1, 8, 8, 1, 1, 0, 0, 0));
    put(32'h218, {32'hA00, 32'h900});
    ws = wcnt;
    pulse_poll();
    send_beat(64'hE1, 1, 0, 0);
    send_beat(64'hE2, 0, 1, 3);
    wait_nodesc("R8 stall at base");
    chk("R8 three writes", 64'(wcnt - ws), 64'd3);
    chk("R8 buffer 2 used despite chain", 64'(wlog[ws+1]), 64'hA00);
    chk("R8 buffer 2 data", mem[32'hA00 >> 3], 64'hE2);
    chk("R10 ring status", mem[32'h210 >> 3], mk_w0(0, 8, 8, 1, 1, 1, 1, 11));
    chk("R8 wrap to base", 64'(rlog[rcnt-1]), 64'h100);
  endtask

  initial begin
    t_reset_stall();
    t_single_frame();
    t_chain_split();
    t_end_ring();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule